// File: doc/BRIEF.md
# SPI Flash Memory-Mapped Read Translator

This block turns a single bus read into a full serial flash read sequence and returns one 32-bit word. Each sequence sends an opcode, then a programmable number of address bytes, then a programmable stretch of idle (dummy) clocks, and then clocks in four data bytes. The data bytes arrive on one lane or on four lanes. A single setup word holds the whole read protocol: opcode, address length, dummy length and data lane mode.

The serial port is shared with a separate command-mode engine. An ownership bit decides whether this translator may drive the port. A read that arrives while the translator does not own the port is answered at once with an error flag and causes no serial activity. The serial clock runs at half the system clock, idles low, and samples input on its rising edge (SPI mode 0).

Top module: `flash_xip_reader`

## Requirements
- R1: After reset, spi_cs_n is 1, spi_sclk is 0, spi_io_oe is 0, rd_valid is 0 and port_mm is 0 (the command-mode engine owns the port).
- R2: Every sequence begins with the opcode from setup bits 7:0, sent most significant bit first on lane 0. spi_io_oe is 4'b0001 for every opcode and address clock and is 0 for every later clock.
- R3: The number of address bytes is setup bits 9:8 plus one. They are the lowest bytes of rd_addr, sent most significant bit first on lane 0 after the opcode.
- R4: After the address come 8 x setup[11:10] + setup[28:24] dummy clocks, during which no lane is driven.
- R5: When setup bits 13:12 equal 3, data is read in 8 clocks of 4 bits each. spi_io_i[3] is the most significant bit of each nibble, and the high nibble of each byte arrives first. Any other value reads 32 clocks of one bit each on spi_io_i[1], most significant bit first.
- R6: The four received bytes are packed little-endian: the first byte received lands in rd_data[7:0] and the last in rd_data[31:24].
- R7: spi_cs_n stays low from the request until after the last data clock. It rises in the same cycle that rd_valid goes high for exactly one cycle with rd_err at 0.
- R8: A configuration write with cfg_sel at 1 sets port ownership from cfg_wdata[0], where 1 means this translator owns the port. port_mm shows the current owner. A write with cfg_sel at 0 loads the setup word.
- R9: A request while port_mm is 0 produces rd_valid, rd_err at 1 and rd_data at 0 in the next cycle, with no serial clock edge and no chip-select activity.
- R10: The number of serial clock rising edges in a sequence is 8 + 8 x (address bytes) + dummy clocks + data clocks.
- R11: The setup word is captured when a request is accepted, so a setup write during a sequence does not change that sequence.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_sel | input | 1 | 0 selects the setup word, 1 selects the ownership bit |
| cfg_wdata | input | 32 | Configuration write data |
| rd_req | input | 1 | Read request, accepted when no sequence is in progress |
| rd_addr | input | 32 | Flash byte address of the read |
| rd_valid | output | 1 | One-cycle response strobe |
| rd_data | output | 32 | Returned word, little-endian |
| rd_err | output | 1 | Response error: port not owned |
| port_mm | output | 1 | 1 while the translator owns the serial port |
| spi_sclk | output | 1 | Serial clock |
| spi_cs_n | output | 1 | Flash chip select, active low |
| spi_io_o | output | 4 | Serial lane output values |
| spi_io_oe | output | 4 | Serial lane output enables |
| spi_io_i | input | 4 | Serial lane input values |

## Verification
A wrong phase counter or a wrongly captured setup word shows at the ports within the first few dozen serial clocks. It appears as a wrong opcode or address bit on lane 0, a lane that stays driven into the dummy stretch, or a rising-edge count that does not match the formula. A fault in data capture or byte ordering stays hidden until the response strobe, where the returned word differs from the bytes the flash model supplied. Ownership faults show in the cycle after the request, as a missing error response or as a chip-select edge.

// File: rtl/xip_pkg.sv
package xip_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_TX,
    ST_DUMMY,
    ST_DATA,
    ST_END
  } xip_state_e;

  // decoded setup word fields
  typedef struct packed {
    logic [4:0] dbits;
    logic [1:0] rmode;
    logic [1:0] dbytes;
    logic [1:0] abytes;
    logic [7:0] opcode;
  } setup_t;

  localparam logic [1:0] RMODE_QUAD = 2'd3;

endpackage

// File: rtl/xip_cfg_regs.sv
module xip_cfg_regs
  import xip_pkg::*;
#(
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              we,
  input  logic              sel,
  input  logic [DATA_W-1:0] wdata,
  output setup_t            setup,
  output logic              mm_own
);

  setup_t setup_q, setup_d;
  logic   own_q, own_d;
  logic   unused_bits;

  assign unused_bits = ^{wdata[DATA_W-1:29], wdata[23:14]};

  always_comb begin
    setup_d = setup_q;
    own_d   = own_q;
    if (we && !sel) begin
      setup_d.opcode = wdata[7:0];
      setup_d.abytes = wdata[9:8];
      setup_d.dbytes = wdata[11:10];
      setup_d.rmode  = wdata[13:12];
      setup_d.dbits  = wdata[28:24];
    end
    if (we && sel) begin
      own_d = wdata[0];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      setup_q <= '{dbits: 5'd0, rmode: 2'd0, dbytes: 2'd0, abytes: 2'd2, opcode: 8'h03};
      own_q   <= 1'b0;
    end else begin
      setup_q <= setup_d;
      own_q   <= own_d;
    end
  end

  assign setup  = setup_q;
  assign mm_own = own_q;

  // R8
  own_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (we && sel) |=> (mm_own == $past(wdata[0])));

endmodule

// File: rtl/xip_rx_shift.sv
module xip_rx_shift #(
  parameter int LANES  = 4,
  parameter int WORD_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              clr,
  input  logic              cap_en,
  input  logic              quad,
  input  logic [LANES-1:0]  lanes_in,
  output logic [WORD_W-1:0] word_le
);

  localparam int BYTES = WORD_W / 8;

  logic [WORD_W-1:0] sh_q, sh_d;

  always_comb begin
    sh_d = sh_q;
    if (clr) begin
      sh_d = '0;
    end else if (cap_en) begin
      if (quad) sh_d = {sh_q[WORD_W-LANES-1:0], lanes_in};
      else      sh_d = {sh_q[WORD_W-2:0], lanes_in[1]};
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sh_q <= '0;
    else        sh_q <= sh_d;
  end

  // first byte shifted in ends up in the top byte; swap to little-endian
  for (genvar g = 0; g < BYTES; g++) begin : g_swap
    assign word_le[g*8 +: 8] = sh_q[(BYTES-1-g)*8 +: 8];
  end

endmodule

// File: rtl/xip_seq.sv
module xip_seq
  import xip_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int CMD_W  = 8,
  parameter int LANES  = 4,
  parameter int WORD_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              rd_req,
  input  logic [ADDR_W-1:0] rd_addr,
  input  setup_t            setup,
  input  logic              mm_own,
  input  logic [WORD_W-1:0] rx_word,
  output logic              rd_valid,
  output logic [WORD_W-1:0] rd_data,
  output logic              rd_err,
  output logic              sclk,
  output logic              cs_n,
  output logic [LANES-1:0]  io_out,
  output logic [LANES-1:0]  io_oe,
  output logic              cap_en,
  output logic              cap_clr,
  output logic              quad
);

  localparam int TX_W  = CMD_W + ADDR_W;
  localparam int CNT_W = $clog2(TX_W + 64);
  localparam logic [LANES-1:0] LANE0 = LANES'(1);

  xip_state_e        st_q, st_d;
  setup_t            set_q, set_d;
  logic              ph_q, ph_d;
  logic [CNT_W-1:0]  cnt_q, cnt_d;
  logic [TX_W-1:0]   tx_q, tx_d;
  logic              sclk_q, sclk_d, cs_q, cs_d;
  logic [LANES-1:0]  oe_q, oe_d;
  logic              val_q, val_d, err_q, err_d;
  logic [WORD_W-1:0] dat_q, dat_d;

  logic [CNT_W-1:0]  a_bits, tx_bits, dum_clks, dat_clks;
  logic [ADDR_W-1:0] addr_al;

  always_comb begin
    a_bits   = (CNT_W'(setup.abytes) + CNT_W'(1)) << 3;
    tx_bits  = CNT_W'(CMD_W) + a_bits;
    addr_al  = rd_addr << (CNT_W'(ADDR_W) - a_bits);
    dum_clks = (CNT_W'(set_q.dbytes) << 3) + CNT_W'(set_q.dbits);
    dat_clks = (set_q.rmode == RMODE_QUAD) ? CNT_W'(WORD_W / LANES) : CNT_W'(WORD_W);
  end

  always_comb begin
    st_d    = st_q;
    set_d   = set_q;
    ph_d    = ph_q;
    cnt_d   = cnt_q;
    tx_d    = tx_q;
    sclk_d  = sclk_q;
    cs_d    = cs_q;
    oe_d    = oe_q;
    val_d   = 1'b0;
    err_d   = err_q;
    dat_d   = dat_q;
    cap_en  = 1'b0;
    cap_clr = 1'b0;
    case (st_q)
      ST_IDLE: begin
        if (rd_req) begin
          if (mm_own) begin
            set_d   = setup;
            tx_d    = {setup.opcode, addr_al};
            cnt_d   = tx_bits - CNT_W'(1);
            cs_d    = 1'b0;
            oe_d    = LANE0;
            ph_d    = 1'b0;
            cap_clr = 1'b1;
            st_d    = ST_TX;
          end else begin
            val_d = 1'b1;
            err_d = 1'b1;
            dat_d = '0;
          end
        end
      end
      ST_TX: begin
        if (!ph_q) begin
          sclk_d = 1'b1;
          ph_d   = 1'b1;
        end else begin
          sclk_d = 1'b0;
          ph_d   = 1'b0;
          tx_d   = tx_q << 1;
          if (cnt_q == '0) begin
            oe_d = '0;
            if (dum_clks != '0) begin
              st_d  = ST_DUMMY;
              cnt_d = dum_clks - CNT_W'(1);
            end else begin
              st_d  = ST_DATA;
              cnt_d = dat_clks - CNT_W'(1);
            end
          end else begin
            cnt_d = cnt_q - CNT_W'(1);
          end
        end
      end
      ST_DUMMY: begin
        if (!ph_q) begin
          sclk_d = 1'b1;
          ph_d   = 1'b1;
        end else begin
          sclk_d = 1'b0;
          ph_d   = 1'b0;
          if (cnt_q == '0) begin
            st_d  = ST_DATA;
            cnt_d = dat_clks - CNT_W'(1);
          end else begin
            cnt_d = cnt_q - CNT_W'(1);
          end
        end
      end
      ST_DATA: begin
        if (!ph_q) begin
          sclk_d = 1'b1;
          ph_d   = 1'b1;
          cap_en = 1'b1;
        end else begin
          sclk_d = 1'b0;
          ph_d   = 1'b0;
          if (cnt_q == '0) st_d = ST_END;
          else             cnt_d = cnt_q - CNT_W'(1);
        end
      end
      ST_END: begin
        cs_d  = 1'b1;
        val_d = 1'b1;
        err_d = 1'b0;
        dat_d = rx_word;
        st_d  = ST_IDLE;
      end
      default: st_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q   <= ST_IDLE;
      set_q  <= '0;
      ph_q   <= 1'b0;
      cnt_q  <= '0;
      tx_q   <= '0;
      sclk_q <= 1'b0;
      cs_q   <= 1'b1;
      oe_q   <= '0;
      val_q  <= 1'b0;
      err_q  <= 1'b0;
      dat_q  <= '0;
    end else begin
      st_q   <= st_d;
      set_q  <= set_d;
      ph_q   <= ph_d;
      cnt_q  <= cnt_d;
      tx_q   <= tx_d;
      sclk_q <= sclk_d;
      cs_q   <= cs_d;
      oe_q   <= oe_d;
      val_q  <= val_d;
      err_q  <= err_d;
      dat_q  <= dat_d;
    end
  end

  assign rd_valid = val_q;
  assign rd_data  = dat_q;
  assign rd_err   = err_q;
  assign sclk     = sclk_q;
  assign cs_n     = cs_q;
  assign io_out   = {{(LANES-1){1'b0}}, tx_q[TX_W-1]};
  assign io_oe    = oe_q;
  assign quad     = (set_q.rmode == RMODE_QUAD);

  // R7
  idle_cs_high_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == ST_IDLE) |-> cs_n);

  // R9
  sclk_needs_cs_chk: assert property (@(posedge clk) disable iff (!rst_n)
    sclk |-> !cs_n);

  // R9
  err_resp_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == ST_IDLE && rd_req && !mm_own) |=> (rd_valid && rd_err && cs_n && !sclk));

  // R7
  valid_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rd_valid |=> !rd_valid);

  // R4
  rx_lanes_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == ST_DUMMY || st_q == ST_DATA) |-> (io_oe == '0));

  // R2
  tx_lane_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (io_oe == '0) || (io_oe == LANE0));

endmodule

// File: rtl/flash_xip_reader.sv
module flash_xip_reader
  import xip_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int LANES  = 4,
  parameter int WORD_W = 32,
  parameter int CFG_W  = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_we,
  input  logic              cfg_sel,
  input  logic [CFG_W-1:0]  cfg_wdata,
  input  logic              rd_req,
  input  logic [ADDR_W-1:0] rd_addr,
  output logic              rd_valid,
  output logic [WORD_W-1:0] rd_data,
  output logic              rd_err,
  output logic              port_mm,
  output logic              spi_sclk,
  output logic              spi_cs_n,
  output logic [LANES-1:0]  spi_io_o,
  output logic [LANES-1:0]  spi_io_oe,
  input  logic [LANES-1:0]  spi_io_i
);

  logic [1:0]        rst_pipe;
  logic              rst_s_n;
  setup_t            setup;
  logic              mm_own;
  logic [WORD_W-1:0] rx_word;
  logic              cap_en, cap_clr, quad;

  // asynchronous assertion, synchronous release
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe <= 2'b00;
    else        rst_pipe <= {rst_pipe[0], 1'b1};
  end
  assign rst_s_n = rst_pipe[1];

  xip_cfg_regs #(.DATA_W(CFG_W)) u_cfg (
    .clk    (clk),
    .rst_n  (rst_s_n),
    .we     (cfg_we),
    .sel    (cfg_sel),
    .wdata  (cfg_wdata),
    .setup  (setup),
    .mm_own (mm_own)
  );

  xip_seq #(.ADDR_W(ADDR_W), .CMD_W(8), .LANES(LANES), .WORD_W(WORD_W)) u_seq (
    .clk      (clk),
    .rst_n    (rst_s_n),
    .rd_req   (rd_req),
    .rd_addr  (rd_addr),
    .setup    (setup),
    .mm_own   (mm_own),
    .rx_word  (rx_word),
    .rd_valid (rd_valid),
    .rd_data  (rd_data),
    .rd_err   (rd_err),
    .sclk     (spi_sclk),
    .cs_n     (spi_cs_n),
    .io_out   (spi_io_o),
    .io_oe    (spi_io_oe),
    .cap_en   (cap_en),
    .cap_clr  (cap_clr),
    .quad     (quad)
  );

  xip_rx_shift #(.LANES(LANES), .WORD_W(WORD_W)) u_rx (
    .clk      (clk),
    .rst_n    (rst_s_n),
    .clr      (cap_clr),
    .cap_en   (cap_en),
    .quad     (quad),
    .lanes_in (spi_io_i),
    .word_le  (rx_word)
  );

  assign port_mm = mm_own;

endmodule

// File: tb/sim_flash_xip_reader.sv
`timescale 1ns/1ps
module sim_flash_xip_reader;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        cfg_we, cfg_sel, rd_req;
  logic [31:0] cfg_wdata, rd_addr;
  logic        rd_valid, rd_err, port_mm, spi_sclk, spi_cs_n;
  logic [31:0] rd_data;
  logic [3:0]  spi_io_o, spi_io_oe;
  logic [3:0]  spi_io_i = 4'h0;

  int n_chk = 0, n_fail = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  flash_xip_reader u0 (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_sel(cfg_sel), .cfg_wdata(cfg_wdata),
    .rd_req(rd_req), .rd_addr(rd_addr), .rd_valid(rd_valid), .rd_data(rd_data),
    .rd_err(rd_err), .port_mm(port_mm), .spi_sclk(spi_sclk), .spi_cs_n(spi_cs_n),
    .spi_io_o(spi_io_o), .spi_io_oe(spi_io_oe), .spi_io_i(spi_io_i)
  );

  // flash content
  function automatic logic [7:0] mem_byte(input logic [31:0] a);
    return (a[7:0] * 8'd29) ^ a[15:8] ^ 8'hA5;
  endfunction

  // ---------------- flash model ----------------
  int          m_txbits = 32, m_pre = 32;
  bit          m_quad = 0;
  int          clk_cnt = 0, oe_bad = 0, total_rise = 0;
  logic [7:0]  got_op = '0;
  logic [31:0] got_addr = '0;

  always @(negedge spi_cs_n) begin
    clk_cnt  = 0;
    oe_bad   = 0;
    got_op   = '0;
    got_addr = '0;
  end

  always @(posedge spi_sclk) begin
    total_rise++;
    if (!spi_cs_n) begin
      if (clk_cnt < 8)             got_op   = {got_op[6:0], spi_io_o[0]};
      else if (clk_cnt < m_txbits) got_addr = {got_addr[30:0], spi_io_o[0]};
      if (clk_cnt < m_txbits) begin
        if (spi_io_oe !== 4'b0001) oe_bad++;
      end else if (spi_io_oe !== 4'b0000) oe_bad++;
      clk_cnt++;
    end
  end

  always @(negedge spi_sclk) begin : drv
    int k;
    logic [7:0] b;
    if (!spi_cs_n && clk_cnt >= m_pre) begin
      k = clk_cnt - m_pre;
      if (m_quad) begin
        b = mem_byte(got_addr + 32'(k / 2));
        spi_io_i = (k % 2 == 0) ? b[7:4] : b[3:0];
      end else begin
        b = mem_byte(got_addr + 32'(k / 8));
        spi_io_i = {2'b00, b[7 - (k % 8)], 1'b0};
      end
    end
  end

  // ---------------- helpers ----------------
  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic cfg_write(input logic sel, input logic [31:0] d);
    @(negedge clk);
    cfg_we = 1'b1; cfg_sel = sel; cfg_wdata = d;
    @(negedge clk);
    cfg_we = 1'b0;
  endtask

  task automatic model_setup(input logic [31:0] s);
    int dum;
    m_txbits = 8 + 8 * (int'(s[9:8]) + 1);
    dum      = 8 * int'(s[11:10]) + int'(s[28:24]);
    m_pre    = m_txbits + dum;
    m_quad   = (s[13:12] == 2'd3);
  endtask

  // waits for the response, returns data, err, cs level at response, pulse ok
  task automatic wait_resp(output logic [31:0] d, output logic e, output logic cs, output logic pulse_ok);
    int t = 0;
    while (!rd_valid && t < 3000) begin
      @(negedge clk);
      t++;
    end
    if (t >= 3000) chk("R7 response timeout", 1, 0);
    d = rd_data; e = rd_err; cs = spi_cs_n;
    @(negedge clk);
    pulse_ok = !rd_valid;
  endtask

  task automatic run_vec(input logic [31:0] s, input logic [31:0] a);
    logic [31:0] d, ea, ew, mask;
    logic e, cs, p;
    int dclk;
    cfg_write(1'b0, s);
    model_setup(s);
    dclk = m_quad ? 8 : 32;
    mask = (s[9:8] == 2'd3) ? 32'hFFFF_FFFF : ((32'h1 << (8 * (int'(s[9:8]) + 1))) - 1);
    ea = a & mask;
    for (int j = 0; j < 4; j++) ew[8*j +: 8] = mem_byte(ea + 32'(j));
    @(negedge clk);
    rd_req = 1'b1; rd_addr = a;
    @(negedge clk);
    rd_req = 1'b0;
    wait_resp(d, e, cs, p);
    chk("R2 opcode", 64'(got_op), 64'(s[7:0]));
    chk("R2 lane enables", 64'(oe_bad), 0);
    chk("R3 address bytes", 64'(got_addr), 64'(ea));
    chk("R10 R4 clock count", 64'(clk_cnt), 64'(m_pre + dclk));
    chk("R5 R6 data word", 64'(d), 64'(ew));
    chk("R7 err low", 64'(e), 0);
    chk("R7 cs high at response", 64'(cs), 1);
    chk("R7 one-cycle valid", 64'(p), 1);
  endtask

  // setup, addr
  localparam logic [63:0] VEC [0:6] = '{
    {32'h0000_0203, 32'h0012_3456},
    {32'h0000_060B, 32'h00AB_CDEF},
    {32'h0000_366B, 32'h0000_0100},
    {32'h0000_0313, 32'hDEAD_BEE0},
    {32'h0500_020B, 32'h000F_FFFC},
    {32'h1F00_3CEB, 32'h7700_00AA},
    {32'h0000_120B, 32'h0055_AA00}
  };

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    logic [31:0] d, ew;
    logic e, cs, p;
    int rise0;
    rst_n = 1'b0; cfg_we = 1'b0; cfg_sel = 1'b0; cfg_wdata = '0; rd_req = 1'b0; rd_addr = '0;
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    // R1 reset state
    chk("R1 cs_n", 64'(spi_cs_n), 1);
    chk("R1 sclk", 64'(spi_sclk), 0);
    chk("R1 oe", 64'(spi_io_oe), 0);
    chk("R1 rd_valid", 64'(rd_valid), 0);
    chk("R1 port_mm", 64'(port_mm), 0);

    // R9 request without ownership
    rise0 = total_rise;
    @(negedge clk);
    rd_req = 1'b1; rd_addr = 32'h0000_1234;
    @(negedge clk);
    rd_req = 1'b0;
    chk("R9 valid next cycle", 64'(rd_valid), 1);
    chk("R9 err", 64'(rd_err), 1);
    chk("R9 data zero", 64'(rd_data), 0);
    chk("R9 cs idle", 64'(spi_cs_n), 1);
    repeat (3) @(negedge clk);
    chk("R9 no sclk edge", 64'(total_rise - rise0), 0);

    // R8 ownership handover
    cfg_write(1'b1, 32'h0000_0001);
    chk("R8 port_mm set", 64'(port_mm), 1);

    for (int i = 0; i < 7; i++) run_vec(VEC[i][63:32], VEC[i][31:0]);

    // R11 setup write during a sequence does not disturb it
    cfg_write(1'b0, 32'h0000_0203);
    model_setup(32'h0000_0203);
    for (int j = 0; j < 4; j++) ew[8*j +: 8] = mem_byte(32'h0000_8000 + 32'(j));
    @(negedge clk);
    rd_req = 1'b1; rd_addr = 32'h0000_8000;
    @(negedge clk);
    rd_req = 1'b0;
    repeat (10) @(negedge clk);
    cfg_we = 1'b1; cfg_sel = 1'b0; cfg_wdata = 32'h0000_366B;
    @(negedge clk);
    cfg_we = 1'b0;
    wait_resp(d, e, cs, p);
    chk("R11 data unchanged", 64'(d), 64'(ew));
    chk("R11 clock count", 64'(clk_cnt), 64'(32 + 32));
    chk("R11 opcode", 64'(got_op), 64'h03);

    // R8 releasing the port makes the next read an error
    cfg_write(1'b1, 32'h0000_0000);
    chk("R8 port_mm cleared", 64'(port_mm), 0);
    rise0 = total_rise;
    @(negedge clk);
    rd_req = 1'b1; rd_addr = 32'h0000_0040;
    @(negedge clk);
    rd_req = 1'b0;
    chk("R9 err after release", 64'({rd_valid, rd_err}), 64'h3);
    repeat (3) @(negedge clk);
    chk("R9 no sclk after release", 64'(total_rise - rise0), 0);

    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

endmodule